// File: doc/BRIEF.md
# In-Band Flow Control Calendar Carrier

This block carries a 256-entry XON/XOFF status calendar through the control words of a packet link. A calendar entry of 1 means XON (the channel may send) and 0 means XOFF. The calendar is too large for one control word, so it is spread over successive control words, sixteen entries per word, with one marker bit flagging the word that opens a new round.

On the transmit side the block sits in the control-word path. Each time the framer emits a control word it pulses a strobe. In the same cycle the block overwrites the calendar field and the round-start bit of the passing word and leaves every other bit alone. The status vector is sampled once per round, so all words of a round report one consistent picture. On the receive side the block accepts the calendar slice of each decoded control word, together with a CRC-good flag and an alignment-lost flag. It keeps a registered 256-bit copy of the far end's calendar.

Word layout used on both sides: bit 56 is the round-start marker. Bits 55 down to 40 hold sixteen entries, and bit 55 carries the lowest-numbered entry of the group.

Top module: `fcal_link`

## Requirements
- R1: After a synchronous active-low reset, `rx_status` is all zero and the next transmit control word is the first of a round (bit 56 set, group 0 in the field).
- R2: On the transmit side, bits 55..40 of `tx_word_out` carry the entries of the current group, with bit 55 = entry 16*g and bit 40 = entry 16*g+15. Bits 63..57 and 39..0 equal `tx_word_in`.
- R3: Bit 56 of `tx_word_out` is 1 exactly when the current group is group 0, whatever bit 56 of `tx_word_in` is.
- R4: Each cycle with `tx_word_strobe` high advances the transmit group by one. After group `TX_CAL_LEN/16 - 1` it wraps to group 0. Without a strobe the group holds.
- R5: The group-0 word of a round takes its entries from `tx_status` in that cycle and captures the whole vector. The later groups of that round show the captured value, even if `tx_status` changes.
- R6: A received word that is valid, CRC-good and has field bit 16 (word bit 56) set writes entries 0..15. Each later valid CRC-good word writes the next group. Entry 16*g+k takes field bit 15-k, and the result is visible on `rx_status` one cycle after the word.
- R7: Received words past the sixteenth group of a round leave `rx_status` unchanged.
- R8: When a new round starts before all sixteen groups were received, the groups not rewritten keep their previous values.
- R9: A valid word with `rx_crc_ok` low clears all 256 status bits on the next cycle and updates no entry. Words without the start bit are then ignored until a start word arrives.
- R10: `rx_align_lost` high clears all 256 status bits on the next cycle and also forces a wait for the next start word.
- R11: In a cycle with `rx_valid` and `rx_align_lost` both low, `rx_status` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both directions |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_status | input | 256 | Local calendar, 1 = XON |
| tx_word_strobe | input | 1 | A control word leaves in this cycle |
| tx_word_in | input | 64 | Control word from the framer |
| tx_word_out | output | 64 | Control word with bits 56..40 filled |
| rx_valid | input | 1 | A decoded control word is present |
| rx_cal_field | input | 17 | Bits 56..40 of the received control word |
| rx_crc_ok | input | 1 | CRC of the received word checked good |
| rx_align_lost | input | 1 | Lane alignment lost |
| rx_status | output | 256 | Received calendar, 1 = XON |

## Verification
The bench aims at the bit order inside a group, since a reversed mapping would report each channel's state on its mirror inside the group. It drives a calendar that runs past sixteen groups, where a design without a bound would wrap the write pointer and corrupt group 0. It restarts a round early, where a design that clears on the start marker would lose the later groups. After a CRC failure it sends words without the start bit, which a design that resynchronises blindly would write to stale positions. It also changes the transmit vector in the middle of a round, where a design without a snapshot would mix two states in one round.

// File: rtl/fcal_pkg.sv
// Package: shared constants and helpers for the flow control calendar.
// Assumes a 64-bit control word with the round-start bit at 56 and the
// sixteen-entry field in bits 55..40 (bit 55 = lowest entry of the group).
package fcal_pkg;

    localparam int CAL_MAX   = 256;                 // calendar entries carried
    localparam int GRP_W     = 16;                  // entries per control word
    localparam int MAX_GRPS  = CAL_MAX / GRP_W;     // groups in a full round
    localparam int CW_W      = 64;                  // control word width
    localparam int START_BIT = 56;                  // round-start marker
    localparam int FIELD_HI  = 55;                  // top of the entry field
    localparam int FIELD_LO  = FIELD_HI - GRP_W + 1;

    // Reverse a group: entry k of the group sits at field bit GRP_W-1-k.
    function automatic logic [GRP_W-1:0] swap_order(input logic [GRP_W-1:0] v);
        logic [GRP_W-1:0] r;
        for (int k = 0; k < GRP_W; k++) begin
            r[GRP_W-1-k] = v[k];
        end
        return r;
    endfunction

endpackage

// File: rtl/fcal_tx_seq.sv
// Transmit calendar sequencer.
// Walks the calendar one group per outgoing control word and fills the
// entry field and the round-start bit; all other word bits pass through.
// Assumes the strobe is high only in cycles where a control word leaves.
// The status vector is captured at the group-0 word of every round.
module fcal_tx_seq
    import fcal_pkg::*;
#(
    parameter int CAL_LEN = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CAL_MAX-1:0]  status_in,
    input  logic                strobe,
    input  logic [CW_W-1:0]     word_in,
    output logic [CW_W-1:0]     word_out
);

    localparam int GROUPS = CAL_LEN / GRP_W;
    localparam int IDX_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUPS - 1);

    logic [IDX_W-1:0]   grp_q;
    logic [CAL_MAX-1:0] snap_q;
    logic [CAL_MAX-1:0] src;
    logic [GRP_W-1:0]   grp_bits;
    logic               at_start;
    logic               at_last;

    assign at_start = (grp_q == '0);
    assign at_last  = (grp_q == LAST_IDX);

    // Group pointer: advance per strobe, wrap after the configured length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q <= '0;
        end else if (strobe) begin
            grp_q <= at_last ? '0 : grp_q + IDX_W'(1);
        end
    end

    // Snapshot: capture the whole vector on the word that opens a round.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (strobe && at_start) begin
            snap_q <= status_in;
        end
    end

    // Source select and field build: live vector on group 0, snapshot after.
    always_comb begin
        src      = at_start ? status_in : snap_q;
        grp_bits = swap_order(src[int'(grp_q) * GRP_W +: GRP_W]);
        word_out = word_in;
        word_out[FIELD_HI:FIELD_LO] = grp_bits;
        word_out[START_BIT]         = at_start;
    end

    AST_TX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && at_last |=> grp_q == '0); // R4
    AST_TX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && !at_last |=> grp_q == $past(grp_q) + IDX_W'(1)); // R4
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(grp_q)); // R4
    AST_TX_SNAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe && at_start) |=> $stable(snap_q)); // R5

endmodule

// File: rtl/fcal_rx_tracker.sv
// Receive calendar tracker.
// Rebuilds the far-end calendar from the entry field of received control
// words. Assumes rx_field is bits 56..40 of a decoded word and that CRC and
// alignment results arrive in the same cycle as the word.
// A CRC failure or alignment loss clears everything and waits for the next
// round-start word; groups past the last calendar position are dropped.
module fcal_rx_tracker
    import fcal_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid,
    input  logic [GRP_W:0]      field,
    input  logic                crc_ok,
    input  logic                align_lost,
    output logic [CAL_MAX-1:0]  status
);

    localparam int PTR_W = $clog2(MAX_GRPS + 1);
    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(MAX_GRPS);

    logic [PTR_W-1:0]   ptr_q;
    logic               synced_q;
    logic [CAL_MAX-1:0] status_q;
    logic               hit_err;
    logic               take_start;
    logic               take_next;
    logic [GRP_W-1:0]   entries;

    assign hit_err    = align_lost || (valid && !crc_ok);
    assign take_start = valid && crc_ok && field[GRP_W];
    assign take_next  = valid && crc_ok && !field[GRP_W] && synced_q && (ptr_q < PTR_END);
    assign entries    = swap_order(field[GRP_W-1:0]);

    // Position tracking: restart on the marker, stop at the calendar end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            synced_q <= 1'b0;
        end else if (hit_err) begin
            ptr_q    <= '0;
            synced_q <= 1'b0;
        end else if (take_start) begin
            ptr_q    <= PTR_W'(1);
            synced_q <= 1'b1;
        end else if (take_next) begin
            ptr_q    <= ptr_q + PTR_W'(1);
        end
    end

    // Per-group storage: one slice of the status register per calendar group.
    for (genvar g = 0; g < MAX_GRPS; g++) begin : g_slot
        logic wr_en;
        assign wr_en = (take_start && g == 0) || (take_next && ptr_q == PTR_W'(g));

        // Slice update: clear on error, load on its own group.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status_q[g*GRP_W +: GRP_W] <= '0;
            end else if (hit_err) begin
                status_q[g*GRP_W +: GRP_W] <= '0;
            end else if (wr_en) begin
                status_q[g*GRP_W +: GRP_W] <= entries;
            end
        end
    end

    assign status = status_q;

    AST_RX_CRC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !crc_ok |=> status_q == '0); // R9
    AST_RX_ALIGN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        align_lost |=> status_q == '0); // R10
    AST_RX_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid && !align_lost |=> $stable(status_q)); // R11
    AST_RX_PTR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= PTR_END); // R7
    AST_RX_OVERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        valid && crc_ok && !align_lost && !field[GRP_W] && ptr_q == PTR_END
        |=> $stable(status_q)); // R7

endmodule

// File: rtl/fcal_link.sv
// Flow control calendar carrier, both directions.
// Assumes one clock for the transmit and receive control-word paths.
// TX_CAL_LEN must be a multiple of 16 between 16 and 256.
module fcal_link
    import fcal_pkg::*;
#(
    parameter int TX_CAL_LEN = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [255:0]        tx_status,
    input  logic                tx_word_strobe,
    input  logic [63:0]         tx_word_in,
    output logic [63:0]         tx_word_out,
    input  logic                rx_valid,
    input  logic [16:0]         rx_cal_field,
    input  logic                rx_crc_ok,
    input  logic                rx_align_lost,
    output logic [255:0]        rx_status
);

    fcal_tx_seq #(
        .CAL_LEN (TX_CAL_LEN)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .status_in (tx_status),
        .strobe    (tx_word_strobe),
        .word_in   (tx_word_in),
        .word_out  (tx_word_out)
    );

    fcal_rx_tracker u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (rx_valid),
        .field      (rx_cal_field),
        .crc_ok     (rx_crc_ok),
        .align_lost (rx_align_lost),
        .status     (rx_status)
    );

endmodule

// File: tb/tb_fcal_link.sv
module tb_fcal_link;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [255:0] tx_status;
    logic         tx_word_strobe;
    logic [63:0]  tx_word_in;
    logic [63:0]  tx_word_out;
    logic         rx_valid;
    logic [16:0]  rx_cal_field;
    logic         rx_crc_ok;
    logic         rx_align_lost;
    logic [255:0] rx_status;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    fcal_link dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .tx_status      (tx_status),
        .tx_word_strobe (tx_word_strobe),
        .tx_word_in     (tx_word_in),
        .tx_word_out    (tx_word_out),
        .rx_valid       (rx_valid),
        .rx_cal_field   (rx_cal_field),
        .rx_crc_ok      (rx_crc_ok),
        .rx_align_lost  (rx_align_lost),
        .rx_status      (rx_status)
    );

    // Receive step: valid, start, crc_ok, align_lost, field, group to check, expected (word order)
    typedef struct packed {
        logic        v;
        logic        s;
        logic        c;
        logic        a;
        logic [15:0] pay;
        logic [3:0]  grp;
        logic [15:0] exp;
    } rx_vec_t;

    localparam rx_vec_t RX_TABLE [0:10] = '{
        '{1'b1, 1'b1, 1'b1, 1'b0, 16'hA001, 4'd0, 16'hA001}, // R6 start
        '{1'b1, 1'b0, 1'b1, 1'b0, 16'hB002, 4'd1, 16'hB002}, // R6 next
        '{1'b1, 1'b0, 1'b1, 1'b0, 16'hC003, 4'd2, 16'hC003}, // R6 next
        '{1'b0, 1'b0, 1'b1, 1'b0, 16'hFFFF, 4'd2, 16'hC003}, // R11 idle
        '{1'b1, 1'b1, 1'b1, 1'b0, 16'h1111, 4'd0, 16'h1111}, // R8 early restart
        '{1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 4'd1, 16'hB002}, // R8 group kept
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFF, 4'd0, 16'h0000}, // R9 crc clear
        '{1'b1, 1'b0, 1'b1, 1'b0, 16'h5555, 4'd1, 16'h0000}, // R9 no marker ignored
        '{1'b1, 1'b1, 1'b1, 1'b0, 16'h7777, 4'd0, 16'h7777}, // R6 resync
        '{1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 4'd0, 16'h0000}, // R10 align clear
        '{1'b1, 1'b0, 1'b1, 1'b0, 16'h3333, 4'd0, 16'h0000}  // R10 waits for marker
    };

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Received group in word order: bit 15 = entry 16*g.
    function automatic logic [15:0] rx_grp(input int g);
        logic [15:0] r;
        for (int k = 0; k < 16; k++) r[15-k] = rx_status[g*16+k];
        return r;
    endfunction

    // Expected transmit field for group g of vector v.
    function automatic logic [15:0] tx_exp(input logic [255:0] v, input int g);
        logic [15:0] r;
        for (int k = 0; k < 16; k++) r[15-k] = v[g*16+k];
        return r;
    endfunction

    task automatic rx_step(input logic v, input logic s, input logic c, input logic a,
                           input logic [15:0] pay);
        @(negedge clk);
        rx_valid      = v;
        rx_cal_field  = {s, pay};
        rx_crc_ok     = c;
        rx_align_lost = a;
        @(posedge clk);
        #1;
        rx_valid      = 1'b0;
        rx_align_lost = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [255:0] v1;
        logic [255:0] v2;
        rst_n = 1'b0; tx_status = '0; tx_word_strobe = 1'b0; tx_word_in = '0;
        rx_valid = 1'b0; rx_cal_field = '0; rx_crc_ok = 1'b1; rx_align_lost = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check("R1 rx_status zero", rx_status, '0);
        check("R1 tx start bit", 256'(tx_word_out[56]), 256'(1));

        // Table walk over the receive path
        foreach (RX_TABLE[i]) begin
            rx_step(RX_TABLE[i].v, RX_TABLE[i].s, RX_TABLE[i].c, RX_TABLE[i].a, RX_TABLE[i].pay);
            check($sformatf("R6-table step %0d", i), 256'(rx_grp(int'(RX_TABLE[i].grp))),
                  256'(RX_TABLE[i].exp));
        end
        check("R9 R10 whole status zero", rx_status, '0);

        // R6 bit order: field bit 15 only -> entry 0 only
        rx_step(1'b1, 1'b1, 1'b1, 1'b0, 16'h8000);
        check("R6 bit order", rx_status, 256'(1));

        // R7 long calendar: 16 groups then extra words
        for (int g = 0; g < 16; g++)
            rx_step(1'b1, g == 0, 1'b1, 1'b0, {4'hA, 4'(g), 8'h3C});
        rx_step(1'b1, 1'b0, 1'b1, 1'b0, 16'hFFFF);
        rx_step(1'b1, 1'b0, 1'b1, 1'b0, 16'h0000);
        check("R7 group 0 intact", 256'(rx_grp(0)), 256'(16'hA03C));
        check("R7 group 15 intact", 256'(rx_grp(15)), 256'(16'hAF3C));
        check("R7 group 7 intact", 256'(rx_grp(7)), 256'(16'hA73C));

        // Transmit round with a mid-round vector change
        for (int g = 0; g < 16; g++) v1[g*16 +: 16] = {4'h5, 4'(g), 8'hC1};
        v2 = ~v1;
        for (int g = 0; g < 16; g++) begin
            @(negedge clk);
            tx_word_strobe = 1'b1;
            tx_word_in     = (g == 3) ? 64'h0 : 64'hFFFF_FFFF_FFFF_FFFF;
            tx_status      = (g == 0) ? v1 : v2;
            #1;
            check($sformatf("R5 R2 field group %0d", g), 256'(tx_word_out[55:40]),
                  256'(tx_exp(v1, g)));
            check($sformatf("R3 start group %0d", g), 256'(tx_word_out[56]), 256'(g == 0));
            if (g == 3 || g == 5)
                check("R2 passthrough", 256'({tx_word_out[63:57], tx_word_out[39:0]}),
                      256'({tx_word_in[63:57], tx_word_in[39:0]}));
        end
        // R4 wrap to group 0, live vector
        @(negedge clk);
        tx_status = v2;
        #1;
        check("R4 wrap start bit", 256'(tx_word_out[56]), 256'(1));
        check("R4 wrap field", 256'(tx_word_out[55:40]), 256'(tx_exp(v2, 0)));
        // R4 hold without strobe
        @(negedge clk);
        tx_word_strobe = 1'b0;
        tx_status      = v1;
        repeat (3) @(negedge clk);
        #1;
        check("R4 hold group 1", 256'(tx_word_out[55:40]), 256'(tx_exp(v2, 1)));
        check("R3 no start on group 1", 256'(tx_word_out[56]), 256'(0));

        // R1 reset mid-round returns to group 0
        rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset returns group 0", 256'(tx_word_out[56]), 256'(1));
        check("R1 reset clears rx", rx_status, '0);

        finish_run();
    end

endmodule